// File: doc/BRIEF.md
# I2C Register-Access Target Engine

This block is the serial front end of a small register bank. It listens to an I2C bus as a target (slave), running entirely on a fast system clock. SCL and SDA arrive as asynchronous pin levels. They are resynchronised, cleaned of short pulses, and turned into bus events: START, repeated START, STOP, SCL rising and SCL falling. The engine answers only to a 7-bit address made of a fixed five-bit prefix and two strap pins. It then takes a register pointer byte and, for writes, one data byte.

Write data leaves the block on a valid/ready port. Reads fetch from the register unit over a combinational request port, using the pointer set earlier in the same transaction. When a transaction that wrote data ends with STOP, the block emits a one-cycle commit pulse. The register unit can use that pulse to start a slow non-volatile save.

Back-pressure rules: `wr_valid` stays high, with `wr_addr` and `wr_data` stable, until the register unit raises `wr_ready`. The bus cannot be stretched, so the unit must accept each write before the next data byte could complete, which is at least nine SCL periods later. The read port has no back-pressure. `rd_data` must reflect `rd_addr` in the same cycle that `rd_req` is high.

Top module: `i2c_regtarget`

## Requirements
- R1: After reset, `sda_oe`, `wr_valid`, `rd_req` and `stop_pulse` are all 0.
- R2: The first byte after a START is an identification byte. Its bits 7..3 must be 01010, bit 2 must equal `strap[1]` and bit 1 must equal `strap[0]`. Bit 0 selects the direction, 1 for read and 0 for write. On a match the target pulls SDA low during the ninth SCL clock (ACK). Otherwise it gives no ACK and ignores the bus until the next START.
- R3: In a write, the byte after the identification byte is the register pointer and the next byte is the data. Both are received MSB first and both are ACKed. One write beat then carries `wr_addr` = pointer and `wr_data` = data.
- R4: Any further byte after the data byte of a write gets no ACK and produces no write beat.
- R5: A read transaction writes the pointer, then sends a repeated START and an identification byte with bit 0 = 1. The target then sends the addressed register MSB first, changing SDA only after SCL falls. It keeps sending bytes while the controller ACKs, and releases SDA after a NACK.
- R6: Each transmitted byte is loaded in a cycle where `rd_req` is 1 and `rd_data` is captured. `rd_addr` equals the pointer for every byte of a read, with no increment.
- R7: After STOP ends a transaction in which a data byte was written, `stop_pulse` is high for exactly one cycle. It never rises while `wr_valid` is high. No pulse follows a read-only or rejected transaction.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, the beat holds: `wr_valid`, `wr_addr` and `wr_data` stay unchanged.
- R9: While `boot_busy` is 1, START conditions are ignored and an idle engine stays idle.
- R10: A START seen partway through a byte drops that byte and begins a new identification byte.
- R11: A level change on SCL or SDA lasting fewer than `FILT_CYC` system clocks is suppressed before any event is detected.
- R12: `sda_oe` only becomes asserted while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap | input | 2 | Address strap pins, [1] then [0] in the ID byte |
| boot_busy | input | 1 | 1 while the power-up load is still running |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Register unit accepts the write beat |
| wr_addr | output | 8 | Write register pointer |
| wr_data | output | 8 | Write data |
| rd_req | output | 1 | Read data captured this cycle |
| rd_addr | output | 8 | Current register pointer |
| rd_data | input | 8 | Register contents at `rd_addr` |
| stop_pulse | output | 1 | One-cycle commit pulse after a write transaction |

## Verification
The commit pulse raised by STOP can collide with a write beat that is still waiting for `wr_ready`. In that case both would fall in the same cycle. The bench provokes this by holding `wr_ready` low across the whole write and its STOP. It then checks that the beat is still held, with the data unchanged, and that no commit pulse has appeared. After releasing `wr_ready`, it checks that the write lands first and that exactly one pulse follows, and a monitor flags any cycle where the pulse and `wr_valid` are high together.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 2;
  localparam logic [4:0] ID_PREFIX = 5'b01010;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_SKIP
  } eng_state_t;

  typedef enum logic [1:0] {
    K_ID, K_ADDR, K_DATA, K_DONE
  } rx_kind_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   clean_q;
  logic                   s_lvl;

  assign s_lvl   = sync_q[SYNC_STAGES-1];
  assign clean_o = clean_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  // a new level is accepted only after it has held FILT_CYC cycles in a row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      clean_q <= 1'b1;
    end else if (s_lvl == clean_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      cnt_q   <= '0;
      clean_q <= s_lvl;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  input  logic boot_busy,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign ev_start = scl_f & scl_d & sda_d & ~sda_f & ~boot_busy;
  assign ev_stop  = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_tgt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_f,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               ev_start,
  input  logic               ev_stop,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_ready,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               sda_oe,
  output logic               wr_valid,
  output logic [BYTE_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               rd_req,
  output logic [BYTE_W-1:0]  rd_addr,
  output logic               stop_pulse,
  output logic               idle
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  eng_state_t        state_q;
  rx_kind_t          kind_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] rx_sh, tx_sh, ptr_q;
  logic              go_tx_q, host_ack_q, wrote_q, commit_q;
  logic              id_ok, byte_end, load_tx;

  assign id_ok    = (rx_sh[7:3] == ID_PREFIX) && (rx_sh[2:1] == strap);
  assign byte_end = scl_fall && (cnt_q == LAST_BIT);
  assign load_tx  = !ev_start && !ev_stop && scl_fall &&
                    (((state_q == S_RX_ACK) && go_tx_q) ||
                     ((state_q == S_TX_ACK) && host_ack_q));

  assign rd_req  = load_tx;
  assign rd_addr = ptr_q;
  assign idle    = (state_q == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      kind_q     <= K_ID;
      cnt_q      <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      ptr_q      <= '0;
      go_tx_q    <= 1'b0;
      host_ack_q <= 1'b0;
      wrote_q    <= 1'b0;
      commit_q   <= 1'b0;
      sda_oe     <= 1'b0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      stop_pulse <= 1'b0;
    end else begin
      stop_pulse <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      // commit waits until the last write beat has been taken
      if (commit_q && !wr_valid) begin
        stop_pulse <= 1'b1;
        commit_q   <= 1'b0;
      end

      if (ev_stop) begin
        state_q <= S_IDLE;
        sda_oe  <= 1'b0;
        if (wrote_q) commit_q <= 1'b1;
        wrote_q <= 1'b0;
      end else if (ev_start) begin
        state_q <= S_RX;
        kind_q  <= K_ID;
        cnt_q   <= '0;
        sda_oe  <= 1'b0;
      end else if (load_tx) begin
        tx_sh   <= rd_data;
        sda_oe  <= ~rd_data[BYTE_W-1];
        cnt_q   <= '0;
        state_q <= S_TX;
      end else begin
        unique case (state_q)
          S_RX: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_end) begin
              cnt_q <= '0;
              unique case (kind_q)
                K_ID: begin
                  if (id_ok) begin
                    sda_oe  <= 1'b1;
                    state_q <= S_RX_ACK;
                    go_tx_q <= rx_sh[0];
                    kind_q  <= K_ADDR;
                  end else begin
                    state_q <= S_SKIP;
                  end
                end
                K_ADDR: begin
                  ptr_q   <= rx_sh;
                  sda_oe  <= 1'b1;
                  state_q <= S_RX_ACK;
                  go_tx_q <= 1'b0;
                  kind_q  <= K_DATA;
                end
                K_DATA: begin
                  wr_valid <= 1'b1;
                  wr_addr  <= ptr_q;
                  wr_data  <= rx_sh;
                  wrote_q  <= 1'b1;
                  sda_oe   <= 1'b1;
                  state_q  <= S_RX_ACK;
                  go_tx_q  <= 1'b0;
                  kind_q   <= K_DONE;
                end
                default: state_q <= S_SKIP;
              endcase
            end
          end
          S_RX_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              state_q <= (kind_q == K_DONE) ? S_SKIP : S_RX;
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_end) begin
              sda_oe  <= 1'b0;
              state_q <= S_TX_ACK;
            end else if (scl_fall) begin
              tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx_sh[BYTE_W-2];
            end
          end
          S_TX_ACK: begin
            if (scl_rise)      host_ack_q <= ~sda_f;
            else if (scl_fall) state_q    <= S_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regtarget.sv
module i2c_regtarget
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic               boot_busy,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [BYTE_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               rd_req,
  output logic [BYTE_W-1:0]  rd_addr,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               stop_pulse
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic scl_clean, sda_clean;
  logic scl_rise, scl_fall, ev_start, ev_stop;
  logic eng_idle;

  assign raw_lines = {scl_i, sda_i};
  assign scl_clean = clean_lines[1];
  assign sda_clean = clean_lines[0];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILT_CYC)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lines[g]),
      .clean_o(clean_lines[g])
    );
  end

  i2c_bus_events u_ev (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_clean),
    .sda_f    (sda_clean),
    .boot_busy(boot_busy),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  i2c_byte_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_f     (sda_clean),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .strap     (strap),
    .wr_ready  (wr_ready),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .stop_pulse(stop_pulse),
    .idle      (eng_idle)
  );
endmodule

// File: rtl/i2c_regtarget_chk.sv
module i2c_regtarget_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_oe,
  input logic       boot_busy,
  input logic       eng_idle,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       stop_pulse
);
  a_r12_oe_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  a_r7_commit_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !wr_valid);

  a_r7_commit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse);

  a_r8_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r9_boot_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && boot_busy) |=> eng_idle);
endmodule

bind i2c_regtarget i2c_regtarget_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_f     (scl_clean),
  .sda_oe    (sda_oe),
  .boot_busy (boot_busy),
  .eng_idle  (eng_idle),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .stop_pulse(stop_pulse)
);

// File: tb/i2c_regtarget_tb.sv
module i2c_regtarget_tb;
  localparam int Q = 25;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, scl_drv, sda_drv, boot_busy, wr_ready;
  logic [1:0] strap;
  logic       sda_oe, wr_valid, rd_req, stop_pulse;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [7:0] regs [4];
  logic       ovr_en;
  logic [7:0] ovr_val;
  wire        sda_line = sda_drv & ~sda_oe;

  assign rd_data = ovr_en ? ovr_val : regs[rd_addr[1:0]];

  i2c_regtarget u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .boot_busy(boot_busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .stop_pulse(stop_pulse)
  );

  int n_chk = 0, n_fail = 0, n_wr = 0, n_stop = 0, n_rd = 0, n_clash = 0;
  logic [7:0] last_wa = '0, last_wd = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        regs[wr_addr[1:0]] <= wr_data;
        last_wa <= wr_addr;
        last_wd <= wr_data;
        n_wr    <= n_wr + 1;
      end
      if (stop_pulse) n_stop <= n_stop + 1;
      if (stop_pulse && wr_valid) n_clash <= n_clash + 1;
      if (rd_req) n_rd <= n_rd + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b1; wq(); wq();
  endtask

  task automatic send_bit(input logic b, input bit glitch = 0);
    sda_drv = b; wq();
    scl_drv = 1'b1;
    if (glitch) begin
      wq(10); sda_drv = 1'b0; wq(4); sda_drv = 1'b1; wq(2 * Q - 14);
    end else begin
      wq(2 * Q);
    end
    scl_drv = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    b = sda_line; wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack, input bit glitch = 0);
    logic r;
    for (int i = 7; i >= 0; i--) send_bit(v[i], glitch && (i == 7));
    recv_bit(r);
    ack = !r;
  endtask

  task automatic recv8(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(r);
      v[i] = r;
    end
  endtask

  task automatic write_txn(input logic [7:0] id, input logic [7:0] a, input logic [7:0] d,
                           output bit ai, output bit aa, output bit ad, input bit glitch = 0);
    bus_start();
    send_byte(id, ai);
    send_byte(a, aa);
    send_byte(d, ad, glitch);
    bus_stop();
  endtask

  // id, pointer, data, expected id ACK ; strap fixed at 2'b10
  localparam logic [24:0] VEC [6] = '{
    {8'h54, 8'h01, 8'hC5, 1'b1},
    {8'h50, 8'h01, 8'h11, 1'b0},
    {8'h54, 8'h02, 8'h3D, 1'b1},
    {8'h44, 8'h02, 8'h22, 1'b0},
    {8'h56, 8'h03, 8'h33, 1'b0},
    {8'h54, 8'h03, 8'hFF, 1'b1}
  };

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ai, aa, ad, ax;
    int w0, s0, r0;
    logic [7:0] d;
    for (int i = 0; i < 4; i++) regs[i] = 8'h00;
    rst_n = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1; strap = 2'b10;
    boot_busy = 1'b0; wr_ready = 1'b1; ovr_en = 1'b0; ovr_val = 8'h00;
    wq(5);
    rst_n = 1'b1;
    wq(3);
    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 stop_pulse", stop_pulse, 0);
    wq(20);

    for (int v = 0; v < 6; v++) begin
      w0 = n_wr; s0 = n_stop;
      write_txn(VEC[v][24:17], VEC[v][16:9], VEC[v][8:1], ai, aa, ad);
      chk("R2 id ack", ai, VEC[v][0]);
      if (VEC[v][0]) begin
        chk("R3 pointer ack", aa, 1);
        chk("R3 data ack", ad, 1);
        chk("R3 one write", n_wr - w0, 1);
        chk("R3 write addr", last_wa, VEC[v][16:9]);
        chk("R3 write data", last_wd, VEC[v][8:1]);
        chk("R7 one commit", n_stop - s0, 1);
      end else begin
        chk("R2 ignored after mismatch", {aa, ad}, 0);
        chk("R2 no write", n_wr - w0, 0);
        chk("R7 no commit", n_stop - s0, 0);
      end
    end

    // R5/R6 read with repeated START, per-byte capture, no increment
    w0 = n_wr; s0 = n_stop; r0 = n_rd;
    bus_start();
    send_byte(8'h54, ai);
    send_byte(8'h02, aa);
    bus_start();
    send_byte(8'h55, ax);
    chk("R5 read id ack", {ai, aa, ax}, 3'b111);
    recv8(d);
    chk("R5 first byte MSB first", d, 8'h3D);
    chk("R6 rd_addr", rd_addr, 8'h02);
    ovr_en = 1'b1; ovr_val = 8'h9E;
    send_bit(1'b0);
    recv8(d);
    chk("R6 second byte recaptured", d, 8'h9E);
    send_bit(1'b0);
    recv8(d);
    chk("R6 third byte same register", d, 8'h9E);
    send_bit(1'b1);
    chk("R5 released after NACK", sda_oe, 0);
    bus_stop();
    ovr_en = 1'b0;
    chk("R6 rd_req per byte", n_rd - r0, 3);
    chk("R7 no commit after read", n_stop - s0, 0);
    chk("R5 read writes nothing", n_wr - w0, 0);

    // R9 boot in progress
    boot_busy = 1'b1;
    w0 = n_wr;
    write_txn(8'h54, 8'h00, 8'h5A, ai, aa, ad);
    chk("R9 no ack while booting", ai, 0);
    chk("R9 no write while booting", n_wr - w0, 0);
    boot_busy = 1'b0;

    // R10 START partway through a byte
    w0 = n_wr;
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'h54, ai);
    send_byte(8'h01, aa);
    send_byte(8'h6B, ad);
    bus_stop();
    chk("R10 restart acks", {ai, aa, ad}, 3'b111);
    chk("R10 write after abort", {last_wa, last_wd}, {8'h01, 8'h6B});
    chk("R10 one write", n_wr - w0, 1);

    // R11 short SDA dip while SCL high
    w0 = n_wr;
    write_txn(8'h54, 8'h03, 8'h81, ai, aa, ad, 1'b1);
    chk("R11 glitch ignored acks", {ai, aa, ad}, 3'b111);
    chk("R11 glitch write data", last_wd, 8'h81);
    chk("R11 one write", n_wr - w0, 1);

    // R4 extra data byte
    w0 = n_wr;
    bus_start();
    send_byte(8'h54, ai);
    send_byte(8'h00, aa);
    send_byte(8'h12, ad);
    send_byte(8'h34, ax);
    bus_stop();
    chk("R4 first data acked", ad, 1);
    chk("R4 extra byte not acked", ax, 0);
    chk("R4 single write", n_wr - w0, 1);
    chk("R4 kept first data", last_wd, 8'h12);

    // R8/R7 STOP while write beat is back-pressured
    wr_ready = 1'b0;
    w0 = n_wr; s0 = n_stop;
    write_txn(8'h54, 8'h01, 8'h77, ai, aa, ad);
    wq(100);
    chk("R8 beat held", wr_valid, 1);
    chk("R8 held data", {wr_addr, wr_data}, {8'h01, 8'h77});
    chk("R7 commit waits for beat", n_stop - s0, 0);
    wr_ready = 1'b1;
    wq(10);
    chk("R8 beat accepted", n_wr - w0, 1);
    chk("R8 accepted data", last_wd, 8'h77);
    chk("R7 commit after beat", n_stop - s0, 1);
    chk("R7 never with valid", n_clash, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule